// File: doc/BRIEF.md
# Addressed Serial Parameter Loader

This block holds four 12-bit tuning parameters for a receiver: an integration constant, a decay constant, a lock threshold and an unlock threshold. Software cannot write a parameter in one operation. It loads each bit on its own through an 8-bit control byte. The byte names a target register, a bit address inside that register, the bit value, and a commit strobe.

To set one bit, software writes the control byte twice. The first write has the strobe clear and sets up the fields. The second write carries the same fields with the strobe set, and that write commits the bit. Only a low-to-high change of the strobe, taken between consecutive byte writes, commits a bit. A repeated write with the strobe already high does nothing. All four parameters are driven out together on one flat bus. The integrate register also has its own output for the downstream logic that uses it most.

Top module: `serial_param_loader`

## Requirements
- R1: An active-low asynchronous reset clears all four parameters to zero and clears the stored strobe state.
- R2: Control byte layout: bit 7 is the commit strobe, bit 6 is the data bit, bits 5:4 are the register select (0 integrate, 1 decay, 2 lock threshold, 3 unlock threshold), and bits 3:0 are the bit address. Bit address k addresses bit k of the parameter, counted from its LSB.
- R3: A byte write with bit 7 set, when the previously written byte had bit 7 clear, loads the data bit into the addressed bit. The new value is visible on the outputs from the clock edge that accepts the write.
- R4: A byte write with bit 7 clear changes no parameter.
- R5: A byte write with bit 7 set, when the previous byte also had bit 7 set, changes no parameter, whatever its other fields are.
- R6: A commit changes only the addressed bit of the selected register. Every other bit of every register keeps its value.
- R7: A commit with bit address 12 to 15 changes no register.
- R8: `reg0_o` always equals the integrate parameter, which is bits 11:0 of `params_o`.
- R9: Twelve setup/commit pairs to register 0, one for each bit address from 0 to 11, leave `reg0_o` holding the chosen value, for example 0x555. Each bit takes effect well within 24 cycles of its commit write.
- R10: While `wr_en_i` is low, `wr_data_i` is ignored and neither the parameters nor the strobe state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control byte write enable, one cycle per write |
| wr_data_i | input | 8 | Control byte |
| params_o | output | 48 | Parameters packed as {unlock, lock, decay, integrate}, 12 bits each |
| reg0_o | output | 12 | Integrate parameter, dedicated output |

## Verification
The assertions check on every cycle that a commit cannot repeat on the next write. They also check that any cycle without a commit leaves every register stable, and that a commit touches only the selected register. They check that the addressed bit then holds the committed data, and that out-of-range addresses write nothing. Only the bench scenarios can show the byte layout as seen by software and the full 0x555 load sequence. The same goes for the exact values after mixed orders of setup writes, repeated strobes and idle cycles with junk data, and for the clearing effect of a reset taken mid-operation.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // Control byte bit positions (byte numbered MSB-first: strobe, data, select, address)
  localparam int CTL_W      = 8;
  localparam int STROBE_BIT = 7;
  localparam int DATA_BIT   = 6;
  localparam int SEL_HI     = 5;
  localparam int SEL_LO     = 4;
  localparam int ADDR_HI    = 3;
  localparam int ADDR_LO    = 0;
  localparam int SEL_W      = SEL_HI - SEL_LO + 1;
  localparam int ADDR_W     = ADDR_HI - ADDR_LO + 1;
  localparam int NUM_REGS   = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_INTEGRATE  = 2'd0,
    SEL_DECAY      = 2'd1,
    SEL_LOCK_THR   = 2'd2,
    SEL_UNLOCK_THR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              data;
    reg_sel_e          sel;
    logic [ADDR_W-1:0] addr;
  } bit_cmd_t;
endpackage

// File: rtl/spl_ctl_decode.sv
module spl_ctl_decode
  import spl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  output logic             commit_o,
  output bit_cmd_t         cmd_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      strobe_q <= 1'b0;
    else if (wr_en_i) strobe_q <= wr_data_i[STROBE_BIT];
  end

  // commit only on a 0->1 strobe change between consecutive writes
  assign commit_o   = wr_en_i && wr_data_i[STROBE_BIT] && !strobe_q;
  assign cmd_o.data = wr_data_i[DATA_BIT];
  assign cmd_o.sel  = reg_sel_e'(wr_data_i[SEL_HI:SEL_LO]);
  assign cmd_o.addr = wr_data_i[ADDR_HI:ADDR_LO];

  assert_no_repeat_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_idle_holds_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(strobe_q));
endmodule

// File: rtl/spl_param_bank.sv
module spl_param_bank
  import spl_pkg::*;
#(
  parameter int PARAM_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        commit_i,
  input  bit_cmd_t                    cmd_i,
  output logic [NUM_REGS*PARAM_W-1:0] params_o
);
  logic [PARAM_W-1:0] regs_q [NUM_REGS];
  logic               addr_ok;

  assign addr_ok = 32'(cmd_i.addr) < PARAM_W;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = commit_i && addr_ok && (cmd_i.sel == reg_sel_e'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[r] <= '0;
      else if (hit) regs_q[r][cmd_i.addr] <= cmd_i.data;
    end

    assign params_o[r*PARAM_W +: PARAM_W] = regs_q[r];

    assert_idle_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(regs_q[r]));

    assert_other_reg_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && cmd_i.sel != reg_sel_e'(r)) |=> $stable(regs_q[r]));

    assert_bad_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && 32'(cmd_i.addr) >= PARAM_W) |=> $stable(regs_q[r]));

    assert_bit_loaded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && cmd_i.sel == reg_sel_e'(r) && 32'(cmd_i.addr) < PARAM_W)
      |=> regs_q[r][$past(cmd_i.addr)] == $past(cmd_i.data));
  end
endmodule

// File: rtl/serial_param_loader.sv
module serial_param_loader
  import spl_pkg::*;
#(
  parameter int PARAM_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [7:0]                  wr_data_i,
  output logic [4*PARAM_W-1:0]        params_o,
  output logic [PARAM_W-1:0]          reg0_o
);
  logic     commit;
  bit_cmd_t cmd;

  spl_ctl_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .commit_o (commit),
    .cmd_o    (cmd)
  );

  spl_param_bank #(.PARAM_W(PARAM_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .cmd_i   (cmd),
    .params_o(params_o)
  );

  assign reg0_o = params_o[PARAM_W-1:0];

  assert_reg0_cleared_R1: assert property (@(posedge clk_i)
    !rst_ni |-> reg0_o == '0);
endmodule

// File: tb/sim_serial_param_loader.sv
module sim_serial_param_loader;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 12;

  typedef struct packed {
    logic [7:0]  wbyte;
    logic [47:0] exp;
    logic [7:0]  req;
  } vec_t;

  // expected = {unlock, lock, decay, integrate}
  localparam vec_t TABLE [15] = '{
    '{8'h40, 48'h000_000_000_000, 8'd4},  // R4 setup only
    '{8'hC0, 48'h000_000_000_001, 8'd3},  // R3 int bit0 <- 1
    '{8'hC3, 48'h000_000_000_001, 8'd5},  // R5 strobe already high
    '{8'h55, 48'h000_000_000_001, 8'd4},  // R4
    '{8'hD5, 48'h000_000_020_001, 8'd2},  // R2 decay bit5
    '{8'h6B, 48'h000_000_020_001, 8'd4},  // R4
    '{8'hEB, 48'h000_800_020_001, 8'd6},  // R6 lock bit11 only
    '{8'h7C, 48'h000_800_020_001, 8'd4},  // R4
    '{8'hFC, 48'h000_800_020_001, 8'd7},  // R7 addr 12 ignored
    '{8'h70, 48'h000_800_020_001, 8'd4},  // R4
    '{8'hF0, 48'h001_800_020_001, 8'd2},  // R2 unlock bit0
    '{8'h00, 48'h001_800_020_001, 8'd4},  // R4
    '{8'h80, 48'h001_800_020_000, 8'd3},  // R3 clear int bit0
    '{8'h6F, 48'h001_800_020_000, 8'd4},  // R4
    '{8'hEF, 48'h001_800_020_000, 8'd7}   // R7 addr 15 ignored
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [4*PW-1:0] params;
  logic [PW-1:0] reg0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_param_loader #(.PARAM_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .params_o(params), .reg0_o(reg0)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, sampled at following negedge
  task automatic write_byte(input logic [7:0] b);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    logic [PW-1:0] val;
    val = 12'h555;
    repeat (2) @(negedge clk);
    check("R1", params, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", {36'b0, reg0}, '0);

    foreach (TABLE[i]) begin
      write_byte(TABLE[i].wbyte);
      check($sformatf("R%0d", TABLE[i].req), params, TABLE[i].exp);
    end

    // R9: bitwise load of 0x555 into register 0
    for (int k = 0; k < PW; k++) begin
      write_byte({1'b0, val[k], 2'b00, 4'(k)});
      write_byte({1'b1, val[k], 2'b00, 4'(k)});
      check("R9", {47'b0, reg0[k]}, {47'b0, val[k]});
    end
    check("R9", {36'b0, reg0}, {36'b0, val});
    check("R8", {36'b0, reg0}, {36'b0, params[PW-1:0]});
    check("R6", {12'b0, params[47:12]}, {12'b0, 36'h001_800_020});

    // R10: junk on data bus without enable; strobe state must stay low
    write_byte(8'h00);
    wr_data = 8'hC1;
    repeat (3) @(negedge clk);
    wr_data = '0;
    check("R10", params, 48'h001_800_020_555);
    write_byte(8'h81);  // strobe still low internally -> commit clears int bit1? addr1 data0
    check("R10", params, 48'h001_800_020_555);  // bit1 of 0x555 is 0 already
    write_byte(8'h40);
    write_byte(8'hC1);  // R10 confirms strobe state: previous write had strobe low
    check("R10", params, 48'h001_800_020_557);

    // R1: asynchronous reset mid-cycle
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    check("R1", params, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    write_byte(8'hC0);  // strobe state cleared: commits at once
    check("R1", params, 48'h000_000_000_001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule